// File: doc/BRIEF.md
# Width-Configurable Pattern Step Sequencer

This block is the program counter and control decoder of a digital pattern generator. Each clock in which it runs, it moves to the next pattern step. It also works out which control-memory byte covers the current step. One control byte governs a block of consecutive steps. The block is 2, 4 or 8 steps long, depending on the channel width selected: 32, 16 or 8 channels. Narrower widths give proportionally deeper memory.

The upper nibble of the control byte gives active-low disables for four 8-pin output groups. These disables stay in force for every step of the block. The lower nibble is a command, and the command acts only on the final step of its block. Command 1 is an unconditional jump to the step held in jump register A. Every other command lets the counter advance by one.

The control memory sits outside the block and is read combinationally. The sequencer drives `ctl_addr` and takes the byte back on `ctl_rdata` in the same cycle.

Top module: `pattern_step_seq`

## Requirements
- R1: When `rst` is high at a clock edge, `step_addr` becomes 0 and register A becomes 0 at that edge.
- R2: `ctl_addr` equals `step_addr` shifted right by a number of bits set by `width_sel`. The codes are 0 = 32 channels (shift 1), 1 = 16 channels (shift 2) and 2 = 8 channels (shift 3). Code 3 behaves as code 0.
- R3: While `run` is low, `step_addr` holds its value.
- R4: While `run` is high and no jump is taken, `step_addr` increments by one at each edge. It wraps to 0 at the configured depth, which is 2^STEP_W, 2^(STEP_W+1) or 2^(STEP_W+2) steps for shifts 1, 2 and 3.
- R5: A step is the last step of its block when its low 1, 2 or 3 bits (matching the shift) are all ones. On such a step with `run` high, if `ctl_rdata[3:0]` is 1, the next `step_addr` is register A masked to the configured depth.
- R6: A control byte with any command value other than 1 causes no jump. On steps that are not last in their block, the command field has no effect.
- R7: `grp_en[g]` is the inverse of `ctl_rdata[4+g]`. For example, an upper nibble of 0xC enables groups 0 and 1 and disables groups 2 and 3. The value is the same for every step sharing one control byte.
- R8: Register A loads `jmp_addr` when `jmp_we` is high and `run` is low. A write strobe while `run` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Advance the step counter when high |
| width_sel | input | 2 | Channel width code (0: 32, 1: 16, 2: 8, 3: as 0) |
| jmp_we | input | 1 | Write strobe for jump register A |
| jmp_addr | input | STEP_W+2 | Value written into register A |
| ctl_rdata | input | 8 | Control byte read at `ctl_addr` |
| step_addr | output | STEP_W+2 | Current pattern step |
| ctl_addr | output | STEP_W-1 | Control-memory address covering the current step |
| grp_en | output | 4 | Output enable per 8-pin group |

## Verification
The assertions assume three things about the inputs. First, `width_sel` is changed only while the sequencer is held in reset. Second, `ctl_rdata` always carries the byte stored at the current `ctl_addr`. Third, `rst` is high at the first clock edge. The stimulus meets these conditions in every run:
- The width is set before each reset and is not changed afterwards.
- The control memory is modelled as a bench array read combinationally at `ctl_addr`.
- Jump-register writes are issued only with `run` low, or else deliberately during run to show they are ignored.

// File: rtl/pattern_step_seq.sv
module pattern_step_seq #(
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [1:0]        width_sel,
  input  logic              jmp_we,
  input  logic [STEP_W+1:0] jmp_addr,
  input  logic [7:0]        ctl_rdata,
  output logic [STEP_W+1:0] step_addr,
  output logic [STEP_W-2:0] ctl_addr,
  output logic [3:0]        grp_en
);
  localparam int AW = STEP_W + 2;
  localparam int CW = STEP_W - 1;

  logic [1:0]    shift_n;
  logic [AW-1:0] depth_mask, blk_mask, pc, reg_a, pc_shifted;
  logic          blk_last, take_jump;

  always_comb begin
    case (width_sel)
      2'd1:    shift_n = 2'd2;
      2'd2:    shift_n = 2'd3;
      default: shift_n = 2'd1;
    endcase
  end

  assign depth_mask = {AW{1'b1}} >> (2'd3 - shift_n);
  assign blk_mask   = AW'((1 << shift_n) - 1);
  assign blk_last   = (pc & blk_mask) == blk_mask;
  assign take_jump  = run && blk_last && (ctl_rdata[3:0] == 4'h1);
  assign pc_shifted = pc >> shift_n;
  assign ctl_addr   = pc_shifted[CW-1:0];
  assign step_addr  = pc;
  assign grp_en     = ~ctl_rdata[7:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      reg_a <= '0;
    end else begin
      if (run)
        pc <= take_jump ? (reg_a & depth_mask) : ((pc + 1'b1) & depth_mask);
      if (jmp_we && !run)
        reg_a <= jmp_addr;
    end
  end

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> step_addr == '0);

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(step_addr));

  a_r4_advance: assert property (@(posedge clk) disable iff (rst)
    (run && !take_jump) |=> step_addr == (($past(step_addr) + 1'b1) & $past(depth_mask)));

  a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
    take_jump |=> step_addr == ($past(reg_a) & $past(depth_mask)));

  a_r8_rega_frozen: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(reg_a));
endmodule

// File: tb/pattern_step_seq_test.sv
`timescale 1ns/1ps
module pattern_step_seq_test;
  localparam int STEP_W = 6;
  localparam int AW = STEP_W + 2;
  localparam int CW = STEP_W - 1;

  logic clk = 0, rst = 1, run = 0, jmp_we = 0;
  logic [1:0] width_sel = 0;
  logic [AW-1:0] jmp_addr = 0;
  logic [7:0] ctl_rdata;
  logic [AW-1:0] step_addr;
  logic [CW-1:0] ctl_addr;
  logic [3:0] grp_en;
  logic [7:0] mem [1 << CW];

  int checks = 0, fails = 0;
  int e_pc, e_a, sh, dmask;

  always #2 clk = ~clk;
  always_comb ctl_rdata = mem[ctl_addr];

  pattern_step_seq #(.STEP_W(STEP_W)) uut (
    .clk(clk), .rst(rst), .run(run), .width_sel(width_sel), .jmp_we(jmp_we),
    .jmp_addr(jmp_addr), .ctl_rdata(ctl_rdata), .step_addr(step_addr),
    .ctl_addr(ctl_addr), .grp_en(grp_en));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic set_mode(input int m);
    width_sel = 2'(m);
    sh = (m == 1) ? 2 : (m == 2) ? 3 : 1;
    dmask = (64 << (sh - 1)) - 1;
  endtask

  task automatic check_outputs(input string step_req);
    chk(step_req, int'(step_addr), e_pc);
    chk("R2 ctl_addr", int'(ctl_addr), e_pc >> sh);
    chk("R7 grp_en", int'(grp_en), int'(~mem[e_pc >> sh][7:4]) & 15);
  endtask

  task automatic do_reset();
    rst = 1; run = 0; jmp_we = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    e_pc = 0; e_a = 0;
    check_outputs("R1 reset step");
  endtask

  task automatic tick(input logic r, input logic w, input int a);
    int bm, nxt;
    logic [7:0] b;
    string tag;
    bm = (1 << sh) - 1;
    b = mem[e_pc >> sh];
    tag = "R4/R6 advance";
    if (!r) begin nxt = e_pc; tag = "R3 hold"; end
    else if (((e_pc & bm) == bm) && b[3:0] == 4'h1) begin nxt = e_a & dmask; tag = "R5/R8 jump"; end
    else nxt = (e_pc + 1) & dmask;
    run = r; jmp_we = w; jmp_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    if (w && !r) e_a = a & 255;
    e_pc = nxt;
    check_outputs(tag);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      // R5 R7: control byte 0xC1 at step 0 jumps after last step of block
      set_mode(m);
      for (int i = 0; i < (1 << CW); i++) mem[i] = 8'h00;
      mem[0] = 8'hC1;
      do_reset();
      tick(0, 1, 40);
      for (int k = 0; k < (1 << sh); k++) begin
        chk("R7 block enable 0xC", int'(grp_en), 4'b0011);
        tick(1, 0, 0);
      end
      chk("R5 jump after block", int'(step_addr), 40);

      // sweep with mixed opcodes, stalls, and ignored A writes during run (R8)
      for (int i = 0; i < (1 << CW); i++)
        mem[i] = {4'(i * 7 + m), (i % 5 == 2) ? 4'h1 : 4'(i % 3 + 2)};
      do_reset();
      tick(0, 1, (m * 37 + 9) & 255);
      for (int c = 0; c < 600; c++)
        tick((c % 11) != 4, (c % 13) == 6, (c * 29) & 255);
      tick(0, 1, 3);
      for (int c = 0; c < 300; c++) tick(1, 0, 0);

      // R4: pure no-op sweep wraps at configured depth
      for (int i = 0; i < (1 << CW); i++) mem[i] = {4'(i), 4'h0};
      do_reset();
      for (int c = 0; c <= dmask; c++) tick(1, 0, 0);
      chk("R4 wrap to zero", int'(step_addr), 0);

      // R1: reset mid-run
      tick(1, 0, 0); tick(1, 0, 0);
      do_reset();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule